// File: doc/BRIEF.md
# CAN Controller Interrupt Flag and Code Unit

This block gathers the controller-wide interrupt sources of a CAN protocol engine into sticky flags that only software clears. It watches the operating-mode field for any change, catches rollover pulses from the time-base counter, and catches bandwidth faults: a receive assembly buffer that overflowed or a transmit assembly buffer that underflowed. From the pending flags it forms a 7-bit interrupt code that names the most urgent source, with a fixed value when nothing is pending.

The block also guards transmit data consistency. When the transmit path reports an underflow or an ECC data error, a frame that is about to start is held back. A frame already on the wire is stopped, and the block asks the mode sequencer to move to a degraded mode. A configuration bit chooses that mode: restricted operation or listen-only.

Top module: `can_irq_vec`

## Requirements
- R1: The mode-change flag is set one cycle after `op_mode_i` differs from the value sampled in the previous cycle. The previous value is loaded with `RST_MODE` (3'b100) during reset.
- R2: A one-cycle pulse on `tbc_wrap_i` sets the timer flag in the next cycle.
- R3: `rx_ovf_i` or `tx_unf_i` sets the system-error flag in the next cycle. An ECC error alone (`ecc_err_i`) does not set it.
- R4: Each clear strobe (`clr_mode_i`, `clr_tmr_i`, `clr_sys_i`) clears only its own flag in the next cycle. Clearing the system-error flag removes code 7'h45 from `irq_code_o`.
- R5: When a set event and the clear strobe for the same flag come in the same cycle, the flag ends up set.
- R6: Reset clears all flags and both pulse outputs, and sets `fallback_mode_o` to 3'b111. With no set event and no clear, a flag holds its value.
- R7: `irq_code_o` follows the current flags with a fixed priority: system error gives 7'b1000101 (7'h45), then mode change gives 7'h41, then timer gives 7'h42. With no flag set it gives 7'h40.
- R8: `tx_go_o` equals `tx_start_i` in any cycle where neither `tx_unf_i` nor `ecc_err_i` is high. In a cycle where either is high, `tx_go_o` is 0.
- R9: A data error (`tx_unf_i` or `ecc_err_i`) while `tx_active_i` is high makes `tx_abort_o` and `fallback_req_o` high for exactly the next cycle.
- R10: On each fallback request, `fallback_mode_o` is loaded with 3'b011 (listen-only) if `cfg_lom_i` was 1, or 3'b111 (restricted) if it was 0. Between requests it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode_i | input | 3 | Current operating-mode field |
| tbc_wrap_i | input | 1 | Time-base counter rollover pulse |
| rx_ovf_i | input | 1 | Receive assembly buffer overflow event |
| tx_unf_i | input | 1 | Transmit assembly buffer underflow event |
| ecc_err_i | input | 1 | ECC data error on transmit data |
| tx_active_i | input | 1 | A frame is being transmitted |
| tx_start_i | input | 1 | Request to start a frame |
| cfg_lom_i | input | 1 | Fallback selection: 1 listen-only, 0 restricted |
| clr_mode_i | input | 1 | Software clear of the mode-change flag |
| clr_tmr_i | input | 1 | Software clear of the timer flag |
| clr_sys_i | input | 1 | Software clear of the system-error flag |
| mode_flag_o | output | 1 | Mode-change flag |
| tmr_flag_o | output | 1 | Timer flag |
| sys_flag_o | output | 1 | System-error flag |
| irq_code_o | output | 7 | Interrupt code |
| tx_go_o | output | 1 | Gated start permission |
| tx_abort_o | output | 1 | Stop the frame in progress |
| fallback_req_o | output | 1 | Request a degraded mode |
| fallback_mode_o | output | 3 | Requested degraded mode |

## Verification
The bench puts a set event and a clear for the same flag in one cycle. A design where the clear has priority would drop the flag and lose that interrupt. It raises an ECC error with no buffer fault; a design that wires ECC into the system-error flag would show code 7'h45 there. It clears the system-error flag while the mode flag stays pending; a design with stale code logic would keep 7'h45 instead of falling back to 7'h41. It raises data errors with and without a frame in flight and with both settings of the fallback bit. A design with these wrong would stop idle frames, let a poisoned frame start, or request the wrong mode.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   localparam int unsigned MODE_W_DEF = 3;
   localparam int unsigned CODE_W_DEF = 7;
   localparam logic [MODE_W_DEF-1:0] MODE_CFG      = 3'b100;
   localparam logic [MODE_W_DEF-1:0] MODE_RESTRICT = 3'b111;
   localparam logic [MODE_W_DEF-1:0] MODE_LISTEN   = 3'b011;
   localparam logic [CODE_W_DEF-1:0] CODE_NONE = 7'h40;
   localparam logic [CODE_W_DEF-1:0] CODE_MODE = 7'h41;
   localparam logic [CODE_W_DEF-1:0] CODE_TMR  = 7'h42;
   localparam logic [CODE_W_DEF-1:0] CODE_SYS  = 7'h45;

   localparam int unsigned NFLAG = 3;
   typedef enum logic [1:0] {
      FL_SYS  = 2'd0,
      FL_MODE = 2'd1,
      FL_TMR  = 2'd2
   } flag_idx_e;
endpackage

// File: rtl/can_irq_flag.sv
module can_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_pri
         assign flag_d = set_i | (flag_o & ~clr_i);
      end else begin : g_clr_pri
         assign flag_d = ~clr_i & (set_i | flag_o);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) flag_o <= 1'b0;
      else        flag_o <= flag_d;
   end
endmodule

// File: rtl/can_irq_mode_det.sv
module can_irq_mode_det #(
   parameter int unsigned   MODE_W   = 3,
   parameter logic [MODE_W-1:0] RST_MODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_i,
   output logic              chg_o
);
   logic [MODE_W-1:0] prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= RST_MODE;
      else        prev_q <= mode_i;
   end

   assign chg_o = rst_n && (mode_i != prev_q);
endmodule

// File: rtl/can_irq_encode.sv
module can_irq_encode #(
   parameter int unsigned       CODE_W    = 7,
   parameter logic [CODE_W-1:0] C_NONE    = 7'h40,
   parameter logic [CODE_W-1:0] C_SYS     = 7'h45,
   parameter logic [CODE_W-1:0] C_MODE    = 7'h41,
   parameter logic [CODE_W-1:0] C_TMR     = 7'h42
) (
   input  logic              sys_i,
   input  logic              mode_i,
   input  logic              tmr_i,
   output logic [CODE_W-1:0] code_o
);
   always_comb begin
      if (sys_i)       code_o = C_SYS;
      else if (mode_i) code_o = C_MODE;
      else if (tmr_i)  code_o = C_TMR;
      else             code_o = C_NONE;
   end
endmodule

// File: rtl/can_irq_txguard.sv
module can_irq_txguard #(
   parameter int unsigned       MODE_W    = 3,
   parameter logic [MODE_W-1:0] FB_RESTR  = 3'b111,
   parameter logic [MODE_W-1:0] FB_LISTEN = 3'b011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_err_i,
   input  logic              active_i,
   input  logic              start_i,
   input  logic              lom_i,
   output logic              go_o,
   output logic              abort_o,
   output logic              fb_req_o,
   output logic [MODE_W-1:0] fb_mode_o
);
   logic stop_now;

   assign go_o     = start_i & ~dat_err_i;
   assign stop_now = dat_err_i & active_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort_o   <= 1'b0;
         fb_req_o  <= 1'b0;
         fb_mode_o <= FB_RESTR;
      end else begin
         abort_o  <= stop_now;
         fb_req_o <= stop_now;
         if (stop_now) fb_mode_o <= lom_i ? FB_LISTEN : FB_RESTR;
      end
   end
endmodule

// File: rtl/can_irq_vec.sv
module can_irq_vec
   import can_irq_pkg::*;
#(
   parameter int unsigned       MODE_W    = MODE_W_DEF,
   parameter int unsigned       CODE_W    = CODE_W_DEF,
   parameter logic [MODE_W-1:0] RST_MODE  = MODE_CFG,
   parameter logic [MODE_W-1:0] FB_RESTR  = MODE_RESTRICT,
   parameter logic [MODE_W-1:0] FB_LISTEN = MODE_LISTEN,
   parameter logic [CODE_W-1:0] C_NONE    = CODE_NONE,
   parameter logic [CODE_W-1:0] C_SYS     = CODE_SYS,
   parameter logic [CODE_W-1:0] C_MODE    = CODE_MODE,
   parameter logic [CODE_W-1:0] C_TMR     = CODE_TMR,
   parameter bit                SET_WINS  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] op_mode_i,
   input  logic              tbc_wrap_i,
   input  logic              rx_ovf_i,
   input  logic              tx_unf_i,
   input  logic              ecc_err_i,
   input  logic              tx_active_i,
   input  logic              tx_start_i,
   input  logic              cfg_lom_i,
   input  logic              clr_mode_i,
   input  logic              clr_tmr_i,
   input  logic              clr_sys_i,
   output logic              mode_flag_o,
   output logic              tmr_flag_o,
   output logic              sys_flag_o,
   output logic [CODE_W-1:0] irq_code_o,
   output logic              tx_go_o,
   output logic              tx_abort_o,
   output logic              fallback_req_o,
   output logic [MODE_W-1:0] fallback_mode_o
);
   localparam int unsigned NF = NFLAG;

   generate
      if (MODE_W < 1) begin : g_bad_mode_w
         $error("can_irq_vec: MODE_W must be at least 1");
      end
      if (CODE_W < 2) begin : g_bad_code_w
         $error("can_irq_vec: CODE_W must be at least 2");
      end
      if (C_NONE == C_SYS || C_NONE == C_MODE || C_NONE == C_TMR) begin : g_bad_codes
         $error("can_irq_vec: idle code collides with a source code");
      end
      if (FB_RESTR == FB_LISTEN) begin : g_bad_fb
         $error("can_irq_vec: fallback modes must differ");
      end
   endgenerate

   logic          mode_chg;
   logic          dat_err;
   logic [NF-1:0] set_v;
   logic [NF-1:0] clr_v;
   logic [NF-1:0] flg_v;

   can_irq_mode_det #(
      .MODE_W   (MODE_W),
      .RST_MODE (RST_MODE)
   ) u_mdet (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (op_mode_i),
      .chg_o  (mode_chg)
   );

   assign set_v[FL_SYS]  = rx_ovf_i | tx_unf_i;
   assign set_v[FL_MODE] = mode_chg;
   assign set_v[FL_TMR]  = tbc_wrap_i;
   assign clr_v[FL_SYS]  = clr_sys_i;
   assign clr_v[FL_MODE] = clr_mode_i;
   assign clr_v[FL_TMR]  = clr_tmr_i;

   for (genvar gi = 0; gi < NF; gi++) begin : g_flag
      can_irq_flag #(.SET_WINS(SET_WINS)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set_v[gi]),
         .clr_i  (clr_v[gi]),
         .flag_o (flg_v[gi])
      );
   end

   assign sys_flag_o  = flg_v[FL_SYS];
   assign mode_flag_o = flg_v[FL_MODE];
   assign tmr_flag_o  = flg_v[FL_TMR];

   can_irq_encode #(
      .CODE_W (CODE_W),
      .C_NONE (C_NONE),
      .C_SYS  (C_SYS),
      .C_MODE (C_MODE),
      .C_TMR  (C_TMR)
   ) u_enc (
      .sys_i  (flg_v[FL_SYS]),
      .mode_i (flg_v[FL_MODE]),
      .tmr_i  (flg_v[FL_TMR]),
      .code_o (irq_code_o)
   );

   assign dat_err = tx_unf_i | ecc_err_i;

   can_irq_txguard #(
      .MODE_W    (MODE_W),
      .FB_RESTR  (FB_RESTR),
      .FB_LISTEN (FB_LISTEN)
   ) u_txg (
      .clk       (clk),
      .rst_n     (rst_n),
      .dat_err_i (dat_err),
      .active_i  (tx_active_i),
      .start_i   (tx_start_i),
      .lom_i     (cfg_lom_i),
      .go_o      (tx_go_o),
      .abort_o   (tx_abort_o),
      .fb_req_o  (fallback_req_o),
      .fb_mode_o (fallback_mode_o)
   );
endmodule

// File: rtl/can_irq_vec_chk.sv
module can_irq_vec_chk #(
   parameter int unsigned       MODE_W    = 3,
   parameter int unsigned       CODE_W    = 7,
   parameter logic [MODE_W-1:0] RST_MODE  = 3'b100,
   parameter logic [MODE_W-1:0] FB_RESTR  = 3'b111,
   parameter logic [MODE_W-1:0] FB_LISTEN = 3'b011,
   parameter logic [CODE_W-1:0] C_NONE    = 7'h40,
   parameter logic [CODE_W-1:0] C_SYS     = 7'h45
) (
   input logic              clk,
   input logic              rst_n,
   input logic [MODE_W-1:0] op_mode_i,
   input logic              tbc_wrap_i,
   input logic              rx_ovf_i,
   input logic              tx_unf_i,
   input logic              ecc_err_i,
   input logic              tx_active_i,
   input logic              tx_start_i,
   input logic              cfg_lom_i,
   input logic              clr_mode_i,
   input logic              clr_tmr_i,
   input logic              clr_sys_i,
   input logic              mode_flag_o,
   input logic              tmr_flag_o,
   input logic              sys_flag_o,
   input logic [CODE_W-1:0] irq_code_o,
   input logic              tx_go_o,
   input logic              tx_abort_o,
   input logic              fallback_req_o,
   input logic [MODE_W-1:0] fallback_mode_o
);
   logic [MODE_W-1:0] seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n) seen_q <= RST_MODE;
      else        seen_q <= op_mode_i;
   end

   // R1
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode_i != seen_q) |=> mode_flag_o);
   // R2
   tmr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tbc_wrap_i |=> tmr_flag_o);
   // R3
   sys_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ovf_i || tx_unf_i) |=> (sys_flag_o && irq_code_o == C_SYS));
   // R4
   sys_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_sys_i && !rx_ovf_i && !tx_unf_i) |=> (!sys_flag_o && irq_code_o != C_SYS));
   // R6
   sys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sys_flag_o && !clr_sys_i) |=> sys_flag_o);
   // R7
   idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sys_flag_o && !mode_flag_o && !tmr_flag_o) |-> (irq_code_o == C_NONE));
   // R8
   go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_go_o |-> (tx_start_i && !tx_unf_i && !ecc_err_i));
   // R9
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_unf_i || ecc_err_i) && tx_active_i) |=> (tx_abort_o && fallback_req_o));
   // R10
   fb_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((tx_unf_i || ecc_err_i) && tx_active_i) |=>
         (fallback_mode_o == ($past(cfg_lom_i) ? FB_LISTEN : FB_RESTR)));
   // R10
   fb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fallback_req_o |-> $stable(fallback_mode_o));
endmodule

bind can_irq_vec can_irq_vec_chk #(
   .MODE_W    (MODE_W),
   .CODE_W    (CODE_W),
   .RST_MODE  (RST_MODE),
   .FB_RESTR  (FB_RESTR),
   .FB_LISTEN (FB_LISTEN),
   .C_NONE    (C_NONE),
   .C_SYS     (C_SYS)
) chk_i (.*);

// File: tb/can_irq_vec_tb_top.sv
module can_irq_vec_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] op_mode_i = 3'b100;
   logic       tbc_wrap_i = 0, rx_ovf_i = 0, tx_unf_i = 0, ecc_err_i = 0;
   logic       tx_active_i = 0, tx_start_i = 0, cfg_lom_i = 0;
   logic       clr_mode_i = 0, clr_tmr_i = 0, clr_sys_i = 0;
   logic       mode_flag_o, tmr_flag_o, sys_flag_o;
   logic [6:0] irq_code_o;
   logic       tx_go_o, tx_abort_o, fallback_req_o;
   logic [2:0] fallback_mode_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   // model state
   logic       e_mode = 0, e_tmr = 0, e_sys = 0, e_abort = 0, e_freq = 0;
   logic [2:0] e_prev = 3'b100, e_fmode = 3'b111;

   always #2.5 clk = ~clk;

   can_irq_vec dut_i (.*);

   function automatic logic [6:0] exp_code(logic s, logic m, logic t);
      if (s) return 7'h45;
      if (m) return 7'h41;
      if (t) return 7'h42;
      return 7'h40;
   endfunction

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_regs();
      check("R1 mode flag", mode_flag_o, e_mode);
      check("R2 timer flag", tmr_flag_o, e_tmr);
      check("R3 sys flag", sys_flag_o, e_sys);
      check("R7 code", irq_code_o, exp_code(e_sys, e_mode, e_tmr));
      check("R9 abort", tx_abort_o, e_abort);
      check("R9 fallback req", fallback_req_o, e_freq);
      check("R10 fallback mode", fallback_mode_o, e_fmode);
   endtask

   // drive one cycle's inputs just after a negedge, update model, step to next negedge
   task automatic cyc(logic [2:0] opm, logic tw, logic ro, logic tu, logic ec,
                      logic act, logic st, logic lom, logic cm, logic ct, logic cs);
      logic derr;
      op_mode_i = opm; tbc_wrap_i = tw; rx_ovf_i = ro; tx_unf_i = tu; ecc_err_i = ec;
      tx_active_i = act; tx_start_i = st; cfg_lom_i = lom;
      clr_mode_i = cm; clr_tmr_i = ct; clr_sys_i = cs;
      #1;
      derr = tu | ec;
      check("R8 tx go", tx_go_o, st & ~derr);
      e_mode = (opm != e_prev) ? 1'b1 : (e_mode & ~cm);
      e_prev = opm;
      e_tmr  = tw ? 1'b1 : (e_tmr & ~ct);
      e_sys  = (ro | tu) ? 1'b1 : (e_sys & ~cs);
      e_abort = derr & act;
      e_freq  = derr & act;
      if (derr & act) e_fmode = lom ? 3'b011 : 3'b111;
      @(negedge clk);
      check_regs();
   endtask

   task automatic idle(logic [2:0] opm);
      cyc(opm, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R6: reset state
      check("R6 reset mode flag", mode_flag_o, 0);
      check("R6 reset sys flag", sys_flag_o, 0);
      check("R6 reset fallback mode", fallback_mode_o, 3'b111);
      check("R7 idle code", irq_code_o, 7'h40);
      idle(3'b100);
      check("R6 no spurious flag", irq_code_o, 7'h40);

      // R1 mode change, R2 timer
      idle(3'b000);
      check("R1 change sets flag", mode_flag_o, 1);
      cyc(3'b000, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R7 mode over timer", irq_code_o, 7'h41);
      // R4 clear mode only
      cyc(3'b000, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      check("R4 mode cleared", mode_flag_o, 0);
      check("R4 timer kept", tmr_flag_o, 1);
      check("R7 timer code", irq_code_o, 7'h42);
      cyc(3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);

      // R3 ECC alone does not set sys
      cyc(3'b000, 0, 0, 0, 1, 0, 1, 0, 0, 0, 0);
      check("R3 ecc no sys", sys_flag_o, 0);
      check("R9 idle no abort", tx_abort_o, 0);
      // R3 overflow sets sys, code 45
      cyc(3'b000, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R3 sys code", irq_code_o, 7'h45);
      // R5 set and clear together
      cyc(3'b010, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1);
      check("R5 set wins", sys_flag_o, 1);
      // R4 clear sys, mode remains
      cyc(3'b010, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
      check("R4 sys code removed", irq_code_o, 7'h41);
      idle(3'b010);
      check("R6 hold mode", mode_flag_o, 1);
      // R5 mode set vs clear
      cyc(3'b011, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
      check("R5 mode set wins", mode_flag_o, 1);

      // R9/R10 abort with listen-only, then restricted
      cyc(3'b011, 0, 0, 0, 1, 1, 0, 1, 0, 0, 0);
      check("R9 abort pulse", tx_abort_o, 1);
      check("R10 listen-only", fallback_mode_o, 3'b011);
      idle(3'b011);
      check("R9 pulse ends", fallback_req_o, 0);
      check("R10 held", fallback_mode_o, 3'b011);
      cyc(3'b011, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0);
      check("R10 restricted", fallback_mode_o, 3'b111);

      // random phase
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] m;
         m = (($urandom % 6) == 0) ? 3'($urandom) : op_mode_i;
         cyc(m, ($urandom % 8) == 0, ($urandom % 10) == 0, ($urandom % 12) == 0,
             ($urandom % 12) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
             ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 4) == 0);
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule